// File: doc/BRIEF.md
# BCH Sector Error-Location Corrector

This block repairs one protected sector after a BCH decoder has finished with it. The sector sits in a local byte buffer: 512 data bytes at buffer addresses 0 to 511, and 8 metadata bytes at addresses 512 to 519. A host fills the buffer through a simple byte port. It then pulses `start` with a sector index. The block waits for that sector's decode-complete bit and takes the sector's error count from a packed count word. It then walks the reported bit locations one per clock, inverting each addressed bit in the buffer.

A location may point past the metadata into the parity bytes. Such a location is counted but changes nothing. A count of 0xF, or a count above the configured strength, is reported as uncorrectable and leaves the buffer untouched. If the decode-complete bit never arrives, the job ends with a timeout.

Top module: `bch_loc_corrector`

## Requirements
- R1: After reset `busy`, `done`, `uncorrectable`, `timed_out` are 0 and `fix_count` is 0.
- R2: After a start, the block waits for bit `sect_idx` of `dec_done`. If that bit stays low for TIMEOUT_CYCLES cycles, `done` pulses with `timed_out`=1 and `fix_count`=0. The buffer is not changed, and the pulse comes TIMEOUT_CYCLES cycles after the start is taken.
- R3: The error count of sector s is `err_count_word[4s+3:4s]`. A count of 0 finishes with `fix_count`=0, no flags and no buffer change.
- R4: A count of 4'hF gives `uncorrectable`=1 and `fix_count`=0, and the buffer is not changed.
- R5: The strength is 4+2×`strength_code` for codes 0 to 4, and 12 for any higher code. A count above the strength, other than 4'hF, is handled as in R4. A count equal to the strength is corrected.
- R6: Location i (counting from 0) is taken from 32-bit word i/2 of `loc_bank` (word w at bits 32w+31:32w). Even i uses bits 12:0 of the word and odd i uses bits 28:16.
- R7: A location L below 4096 inverts bit L[2:0] of data byte L>>3.
- R8: A location L from 4096 to 4159 inverts bit L[2:0] of metadata byte (L>>3)−512, which is buffer address L>>3.
- R9: A location of 4160 or more changes no buffer byte but still counts toward `fix_count`.
- R10: A corrected job reports `fix_count` equal to the count. One location is handled per clock. `done` is a one-cycle pulse, raised n+1 cycles after the start is taken when the decode-complete bit is already set (n = count; n = 0 for R3/R4/R5 rejections).
- R11: A `start` while `busy` is high is ignored. The running job keeps its sector and produces exactly one `done`.
- R12: When idle, `host_we` writes `host_wdata` to `host_addr`. `host_rdata` returns the byte at `host_addr` one clock later. Host writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a correction job when idle |
| sect_idx | input | 3 | Sector number of the job |
| strength_code | input | 3 | Selects the correction strength |
| err_count_word | input | 32 | Packed 4-bit error counts, one per sector |
| loc_bank | input | 192 | Six words, two 13-bit locations each |
| dec_done | input | 8 | Decode-complete bit per sector |
| host_we | input | 1 | Buffer byte write strobe |
| host_addr | input | 10 | Buffer byte address |
| host_wdata | input | 8 | Buffer write byte |
| host_rdata | output | 8 | Buffer read byte, one clock latency |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fix_count | output | 4 | Locations processed in the last job |
| uncorrectable | output | 1 | Last job was rejected as uncorrectable |
| timed_out | output | 1 | Last job hit the wait timeout |

## Verification
On every cycle, the assertions check these properties:
- `done` never lasts two cycles.
- A start during a job leaves the captured sector alone.
- A rejected or timed-out job never carries a nonzero count.
- A timeout only arises while waiting.
- No correction write goes beyond the buffer or collides with a host write.

Only the bench's scenarios can show the rest:
- the exact bit each location inverts in data and metadata bytes;
- parity locations leaving every byte intact;
- the slot layout across all six location words;
- the strength boundary;
- the end-of-job latency.

// File: rtl/bcf_pkg.sv
// Shared types for the sector error-location corrector.
// Assumes strengths step by two from 4 up to MAX_T.
package bcf_pkg;
    parameter int MAX_T = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_FIX    = 2'd2,
        ST_REPORT = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        RG_DATA   = 2'd0,
        RG_META   = 2'd1,
        RG_PARITY = 2'd2
    } region_t;

    // Maps a strength code to the number of correctable bits.
    function automatic logic [3:0] strength_limit(input logic [2:0] code);
        logic [4:0] val;
        val = 5'd4 + {1'b0, code, 1'b0};
        if (val > 5'(MAX_T)) val = 5'(MAX_T);
        return val[3:0];
    endfunction
endpackage

// File: rtl/bcf_loc_pick.sv
// Picks error location number idx out of the packed location bank and
// steers it to a buffer byte address and bit mask.
// Assumes the bank is stable while a job walks through its locations.
module bcf_loc_pick
    import bcf_pkg::*;
#(
    parameter int LOC_WORDS  = 6,
    parameter int LOC_W      = 13,
    parameter int IDX_W      = 4,
    parameter int DATA_BYTES = 512,
    parameter int META_BYTES = 8,
    parameter int ADDR_W     = 10
) (
    input  logic [LOC_WORDS*32-1:0] loc_bank,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    active,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [7:0]              wr_mask,
    output region_t                 region
);
    localparam int NSLOT    = LOC_WORDS * 2;
    localparam int SLOTS_P2 = 2 ** IDX_W;
    localparam int DATA_LIM = DATA_BYTES * 8;
    localparam int ALL_LIM  = (DATA_BYTES + META_BYTES) * 8;

    logic [LOC_W-1:0] slot [SLOTS_P2];
    logic [LOC_W-1:0] loc;

    // Unpack two locations per word: even slot low half, odd slot high half.
    generate
        for (genvar j = 0; j < SLOTS_P2; j++) begin : g_slot
            if (j < NSLOT) begin : g_real
                assign slot[j] = loc_bank[(j/2)*32 + (j%2)*16 +: LOC_W];
            end else begin : g_pad
                assign slot[j] = '0;
            end
        end
    endgenerate

    assign loc = slot[idx];

    // Classify the location into data, metadata or parity range.
    always_comb begin
        if (32'(loc) < DATA_LIM)     region = RG_DATA;
        else if (32'(loc) < ALL_LIM) region = RG_META;
        else                         region = RG_PARITY;
    end

    // Byte address is the location over eight; bit is its low three bits.
    always_comb begin
        wr_addr = loc[3 +: ADDR_W];
        wr_mask = 8'(1) << loc[2:0];
        wr_en   = active && (region != RG_PARITY);
    end
endmodule

// File: rtl/bcf_sector_ram.sv
// Byte buffer holding one sector plus its metadata. The host port writes
// and reads with a one-clock read latency. The correction port performs
// a same-cycle read-modify-write XOR and wins over the host.
// Assumes the caller never drives both write strobes in one cycle.
module bcf_sector_ram #(
    parameter int DEPTH  = 520,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              fix_en,
    input  logic [ADDR_W-1:0] fix_addr,
    input  logic [7:0]        fix_mask
);
    logic [7:0] mem [DEPTH];

    // Apply a bit inversion or a host byte write.
    always_ff @(posedge clk) begin
        if (fix_en)       mem[fix_addr]  <= mem[fix_addr] ^ fix_mask;
        else if (host_we) mem[host_addr] <= host_wdata;
    end

    // Registered host read.
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= mem[host_addr];
    end

    // R9
    fix_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |-> (32'(fix_addr) < DEPTH));

    // R12
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fix_en && host_we));
endmodule

// File: rtl/bcf_seq.sv
// Job sequencer: captures the sector, waits for its decode-complete bit
// with a timeout, screens the error count, steps one location per clock,
// and emits a one-cycle done pulse with the held result.
// Assumes the count word is stable once the decode-complete bit is set.
module bcf_seq
    import bcf_pkg::*;
#(
    parameter int MAX_SECT       = 8,
    parameter int SECT_W         = 3,
    parameter int IDX_W          = 4,
    parameter int CNT_W          = 4,
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SECT_W-1:0]     sect_idx,
    input  logic [2:0]            strength_code,
    input  logic [MAX_SECT*4-1:0] err_count_word,
    input  logic [MAX_SECT-1:0]   dec_done,
    output logic [IDX_W-1:0]      loc_idx,
    output logic                  fix_active,
    output logic                  busy,
    output logic                  done,
    output logic [CNT_W-1:0]      fix_count,
    output logic                  uncorrectable,
    output logic                  timed_out
);
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [3:0] CNT_BAD = 4'hF;

    seq_state_t        state;
    logic [SECT_W-1:0] sect_q;
    logic [TMO_W-1:0]  tcnt;
    logic [IDX_W-1:0]  idx_q;
    logic [3:0]        n_q;
    logic [3:0]        nib;
    logic [3:0]        lim;

    assign nib = err_count_word[{sect_q, 2'b00} +: 4];
    assign lim = strength_limit(strength_code);

    // Main job state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            sect_q        <= '0;
            tcnt          <= '0;
            idx_q         <= '0;
            n_q           <= '0;
            fix_count     <= '0;
            uncorrectable <= 1'b0;
            timed_out     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    sect_q        <= sect_idx;
                    tcnt          <= '0;
                    fix_count     <= '0;
                    uncorrectable <= 1'b0;
                    timed_out     <= 1'b0;
                    state         <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (dec_done[sect_q]) begin
                        if (nib == 4'd0) begin
                            state <= ST_REPORT;
                        end else if (nib == CNT_BAD || nib > lim) begin
                            uncorrectable <= 1'b1;
                            state         <= ST_REPORT;
                        end else begin
                            n_q   <= nib;
                            idx_q <= '0;
                            state <= ST_FIX;
                        end
                    end else if (tcnt == TMO_W'(TIMEOUT_CYCLES - 1)) begin
                        timed_out <= 1'b1;
                        state     <= ST_REPORT;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_FIX: begin
                    fix_count <= CNT_W'(idx_q) + 1'b1;
                    if (4'(idx_q) == n_q - 4'd1) state <= ST_REPORT;
                    else                         idx_q <= idx_q + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_REPORT);
    assign fix_active = (state == ST_FIX);
    assign loc_idx    = idx_q;

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sect_q));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4 R5
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (uncorrectable || timed_out)) |-> (fix_count == '0));

    // R2
    timeout_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out) |-> ($past(state) == ST_WAIT));
endmodule

// File: rtl/bch_loc_corrector.sv
// Top of the sector error-location corrector: ties the sequencer, the
// location picker and the sector buffer together and blocks host writes
// while a job runs.
// Assumes location and count inputs stay stable for the job's duration.
module bch_loc_corrector
    import bcf_pkg::*;
#(
    parameter int MAX_SECT       = 8,
    parameter int DATA_BYTES     = 512,
    parameter int META_BYTES     = 8,
    parameter int LOC_W          = 13,
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int SECT_W         = $clog2(MAX_SECT),
    parameter int LOC_WORDS      = (MAX_T + 1) / 2,
    parameter int ADDR_W         = $clog2(DATA_BYTES + META_BYTES),
    parameter int CNT_W          = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SECT_W-1:0]      sect_idx,
    input  logic [2:0]             strength_code,
    input  logic [MAX_SECT*4-1:0]  err_count_word,
    input  logic [LOC_WORDS*32-1:0] loc_bank,
    input  logic [MAX_SECT-1:0]    dec_done,
    input  logic                   host_we,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    output logic                   busy,
    output logic                   done,
    output logic [CNT_W-1:0]       fix_count,
    output logic                   uncorrectable,
    output logic                   timed_out
);
    localparam int DEPTH = DATA_BYTES + META_BYTES;
    localparam int IDX_W = $clog2(MAX_T);

    logic [IDX_W-1:0]  loc_idx;
    logic              fix_active;
    logic              fix_en;
    logic [ADDR_W-1:0] fix_addr;
    logic [7:0]        fix_mask;
    region_t           region;
    logic              host_we_ok;

    // Host writes only land while no job is running.
    assign host_we_ok = host_we && !busy;

    bcf_seq #(
        .MAX_SECT(MAX_SECT), .SECT_W(SECT_W), .IDX_W(IDX_W),
        .CNT_W(CNT_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sect_idx(sect_idx),
        .strength_code(strength_code), .err_count_word(err_count_word),
        .dec_done(dec_done), .loc_idx(loc_idx), .fix_active(fix_active),
        .busy(busy), .done(done), .fix_count(fix_count),
        .uncorrectable(uncorrectable), .timed_out(timed_out)
    );

    bcf_loc_pick #(
        .LOC_WORDS(LOC_WORDS), .LOC_W(LOC_W), .IDX_W(IDX_W),
        .DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES), .ADDR_W(ADDR_W)
    ) u_pick (
        .loc_bank(loc_bank), .idx(loc_idx), .active(fix_active),
        .wr_en(fix_en), .wr_addr(fix_addr), .wr_mask(fix_mask),
        .region(region)
    );

    bcf_sector_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .host_we(host_we_ok),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .fix_en(fix_en), .fix_addr(fix_addr),
        .fix_mask(fix_mask)
    );

    // R8
    meta_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_en && region == RG_META) |-> (32'(fix_addr) >= DATA_BYTES));
endmodule

// File: tb/test_bch_loc_corrector.sv
module test_bch_loc_corrector;
    localparam int TMO   = 40;
    localparam int DEPTH = 520;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   sect_idx = '0;
    logic [2:0]   strength_code = '0;
    logic [31:0]  err_count_word = '0;
    logic [191:0] loc_bank = '0;
    logic [7:0]   dec_done = '0;
    logic         host_we = 1'b0;
    logic [9:0]   host_addr = '0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;
    logic         busy, done, uncorrectable, timed_out;
    logic [3:0]   fix_count;

    bch_loc_corrector #(.TIMEOUT_CYCLES(TMO)) i_bch_loc_corrector (
        .clk(clk), .rst_n(rst_n), .start(start), .sect_idx(sect_idx),
        .strength_code(strength_code), .err_count_word(err_count_word),
        .loc_bank(loc_bank), .dec_done(dec_done), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .done(done),
        .fix_count(fix_count), .uncorrectable(uncorrectable),
        .timed_out(timed_out)
    );

    always #2 clk = ~clk;

    typedef struct {
        int fix; bit unc; bit tout; int lat; int t0; string tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] gold [DEPTH];
    int         cyc = 0;
    int         n_checks = 0;
    int         n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11 extra done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(fix_count == e.fix, {e.tag, " fix_count"}, fix_count, e.fix);
                check(uncorrectable == e.unc, {e.tag, " uncorrectable"}, uncorrectable, e.unc);
                check(timed_out == e.tout, {e.tag, " timed_out"}, timed_out, e.tout);
                if (e.lat > 0)
                    check(cyc - e.t0 == e.lat, {e.tag, " latency"}, cyc - e.t0, e.lat);
            end
        end
    end

    function automatic int limit_of(input int code);
        return (code <= 4) ? 4 + 2 * code : 12;
    endfunction

    function automatic void set_loc(input int i, input int v);
        loc_bank[(i/2)*32 + (i%2)*16 +: 13] = 13'(v);
    endfunction

    function automatic int get_loc(input int i);
        return int'(loc_bank[(i/2)*32 + (i%2)*16 +: 13]);
    endfunction

    // Golden model: invert each in-range location's bit.
    function automatic void apply_gold(input int n);
        for (int i = 0; i < n; i++) begin
            int l;
            l = get_loc(i);
            if (l < DEPTH * 8) gold[l >> 3] = gold[l >> 3] ^ 8'(1 << (l & 7));
        end
    endfunction

    // Driver: launch a job and push its expected outcome.
    task automatic run_job(input int s, input int code, input int n,
                           input bit tout, input int lat, input string tag,
                           input bit wait_end);
        exp_t e;
        bit   unc;
        int   fx;
        unc = !tout && (n == 15 || n > limit_of(code));
        fx  = (tout || unc) ? 0 : n;
        if (fx > 0) apply_gold(n);
        @(negedge clk);
        sect_idx = 3'(s); strength_code = 3'(code); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.fix = fx; e.unc = unc; e.tout = tout; e.lat = lat; e.t0 = cyc; e.tag = tag;
        sb_q.push_back(e);
        if (wait_end) begin
            wait (sb_q.size() == 0);
            @(negedge clk);
        end
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 10'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 10'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic compare_all(input string tag);
        int bad = -1;
        logic [7:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a, d);
            if (bad < 0 && d !== gold[a]) begin
                bad = a;
                check(1'b0, {tag, " buffer byte"}, int'(d), int'(gold[a]));
            end
        end
        if (bad < 0) check(1'b1, tag, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !uncorrectable && !timed_out && fix_count == 0,
              "R1 reset", {busy, done, uncorrectable, timed_out}, 0);

        // R12 fill the buffer and read it back
        for (int a = 0; a < DEPTH; a++) begin
            gold[a] = 8'(a * 7 + 3);
            @(negedge clk);
            host_we = 1'b1; host_addr = 10'(a); host_wdata = gold[a];
        end
        @(negedge clk);
        host_we = 1'b0;
        compare_all("R12 load");

        // R7 R8 R6 R10 data and metadata flips, latency n+1
        dec_done = 8'hFF;
        err_count_word = '0;
        err_count_word[2*4 +: 4] = 4'd3;
        set_loc(0, 0); set_loc(1, 4095); set_loc(2, 4100);
        run_job(2, 4, 3, 1'b0, 4, "R7 R8 R10 mixed", 1'b1);
        host_read(0, d);   check(d == gold[0], "R7 data byte 0", d, gold[0]);
        host_read(511, d); check(d == gold[511], "R7 data byte 511", d, gold[511]);
        host_read(512, d); check(d == gold[512], "R8 metadata byte 0", d, gold[512]);

        // R9 parity locations counted, not applied
        err_count_word[5*4 +: 4] = 4'd4;
        set_loc(0, 4160); set_loc(1, 37*8 + 2); set_loc(2, 8191); set_loc(3, 4159);
        run_job(5, 4, 4, 1'b0, 5, "R9 parity", 1'b1);
        compare_all("R9 buffer");

        // R3 zero count
        err_count_word[0 +: 4] = 4'd0;
        run_job(0, 4, 0, 1'b0, 1, "R3 zero count", 1'b1);

        // R4 uncorrectable code
        err_count_word[6*4 +: 4] = 4'hF;
        set_loc(0, 8); set_loc(1, 16);
        run_job(6, 4, 15, 1'b0, 1, "R4 all-ones count", 1'b1);
        compare_all("R4 buffer");

        // R5 count above strength 4
        err_count_word[7*4 +: 4] = 4'd5;
        run_job(7, 0, 5, 1'b0, 1, "R5 above strength", 1'b1);
        compare_all("R5 buffer");

        // R5 count equal to strength 6
        err_count_word[7*4 +: 4] = 4'd6;
        for (int i = 0; i < 6; i++) set_loc(i, 200 + 9 * i);
        run_job(7, 1, 6, 1'b0, 7, "R5 at strength", 1'b1);

        // R6 all twelve slots, code above range clamps to 12
        err_count_word[1*4 +: 4] = 4'd12;
        for (int i = 0; i < 12; i++) set_loc(i, 4096 + 5 * i);
        run_job(1, 7, 12, 1'b0, 13, "R6 twelve slots", 1'b1);
        compare_all("R6 buffer");

        // R2 timeout
        dec_done = 8'h00;
        err_count_word[3*4 +: 4] = 4'd2;
        run_job(3, 4, 2, 1'b1, TMO, "R2 timeout", 1'b1);
        compare_all("R2 buffer");

        // R11 R12 start and host write while busy are ignored
        dec_done = 8'b0000_1000;
        err_count_word[1*4 +: 4] = 4'd2;
        err_count_word[3*4 +: 4] = 4'd1;
        set_loc(0, 10*8 + 1); set_loc(1, 20*8 + 6);
        run_job(1, 4, 2, 1'b0, 0, "R11 busy start", 1'b0);
        repeat (3) @(negedge clk);
        sect_idx = 3'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        host_write(10, 0);
        check(busy == 1'b1, "R11 still waiting", busy, 1);
        dec_done[1] = 1'b1;
        wait (sb_q.size() == 0);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0 && !busy, "R11 single done", busy, 0);
        host_read(10, d); check(d == gold[10], "R12 busy write ignored", d, gold[10]);
        host_read(20, d); check(d == gold[20], "R11 sector kept", d, gold[20]);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule